// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block keeps the interrupt state of every locality of a host interface and drives one shared interrupt line. Each locality has an enable register and a status register. The enable register holds a global enable bit, a two-bit polarity code and one enable bit per source. The status register latches the source events that passed both enables. Single-cycle event pulses arrive from the transfer controller and from the locality arbiter. Each pulse is tagged with the locality it belongs to.

Software reaches the registers through a plain register port. The port carries a locality tag, a register select, 32-bit data and byte-lane enables. Only the locality the arbiter reports as active may change its enable register or clear its status bits. Reads are combinational and are allowed from any locality. A read-only vector register returns the line number that was fixed when the block was built. The line is active high in this block. Polarity conversion at the pin and address decoding happen outside it.

Top module: `irqc_top`

## Requirements
- R1: A source pulse for locality L sets the matching status bit of L only when bit 31 (global enable) of L's enable register is set and the enable bit of that source is also set. Both bits are taken as they stood before the clock edge.
- R2: Sources map to bits 0 (locality changed), 1 (command ready), 2 (data available) and 3 (status valid) of both registers. Several sources pulsed in one cycle all latch together, as data available and status valid do when a command completes.
- R3: Writing ones to the status register (select 1) clears those bits. Only bits 3:0 can be cleared, and status bits 31:4 always read 0.
- R4: A write to the enable or status register is ignored when the writing locality is not the active one, or when no locality is active.
- R5: The enable register (select 0) stores only bit 31, the polarity bits 5:4 and the source bits 3:0. All other bits read 0.
- R6: A write changes only the bytes whose lane enable is set. wr_be[i] covers wr_data[8i+7:8i].
- R7: A status write that leaves the writing locality's status at zero drops the line on the next cycle, even if another locality still holds status bits. A write that leaves any bit set keeps the line high.
- R8: When a qualifying event and a clearing write hit the same locality in the same cycle, the event bit stays set and the line stays high.
- R9: After reset every enable register reads 0x0000_0010 (level-low polarity code 01, nothing enabled), every status register reads 0 and the line is low.
- R10: The vector register (select 2) reads the configured line number (default 11) in bits 3:0, with zeros above it. Writes to it are ignored.
- R11: The line rises only in the cycle after a qualifying event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A locality currently owns the interface |
| act_loc | input | LW | Active locality number |
| ev_loc | input | LW | Locality the event pulses belong to |
| ev_src | input | 4 | Event pulses, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_loc | input | LW | Locality of the write |
| wr_sel | input | 2 | Write target: 0 enable, 1 status, 2 vector |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables of the write |
| rd_loc | input | LW | Locality of the read |
| rd_sel | input | 2 | Read target: 0 enable, 1 status, 2 vector, 3 reads 0 |
| rd_data | output | 32 | Combinational read data |
| irq_line | output | 1 | Shared interrupt line, active high |

## Verification
A source pulse and a clearing status write can land on the same locality in the same clock. The bench drives both in one cycle: a locality-changed pulse together with a write that clears the remaining bits. It then expects status to hold only the new bit and the line to stay high. A reference model that updates every clock from the same inputs judges the line on every cycle. This also covers the case where one locality's clear drops the line while another locality still holds status.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int SRC_N = 4;
  localparam int DW = 32;
  localparam int BE_N = DW / 8;

  localparam int SRC_LOC_CHG = 0;
  localparam int SRC_CMD_RDY = 1;
  localparam int SRC_DATA_AV = 2;
  localparam int SRC_STS_VLD = 3;

  localparam int GLB_EN_BIT = 31;
  localparam int POL_LSB = 4;
  localparam int POL_W = 2;

  localparam logic [DW-1:0] SRC_MASK = DW'((1 << SRC_N) - 1);
  localparam logic [DW-1:0] EN_KEEP  = (DW'(1) << GLB_EN_BIT)
                                     | (DW'((1 << POL_W) - 1) << POL_LSB)
                                     | SRC_MASK;
  // polarity code 01 = level low
  localparam logic [DW-1:0] EN_RESET = DW'(1) << POL_LSB;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_VECTOR = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [DW-1:0] lane_mask(input logic [BE_N-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < BE_N; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction
endpackage

// File: rtl/irqc_loc_regs.sv
module irqc_loc_regs
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_here,
  input  logic [SRC_N-1:0] ev_src,
  input  logic             en_wr,
  input  logic             sts_wr,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    wr_mask,
  output logic [DW-1:0]    en_q,
  output logic [SRC_N-1:0] sts_q,
  output logic [SRC_N-1:0] sts_nxt,
  output logic             hit,
  output logic             clr_any
);
  logic [SRC_N-1:0] hit_vec;
  logic [SRC_N-1:0] clr_vec;
  logic [DW-1:0]    en_nxt;

  always_comb begin
    hit_vec = '0;
    if (ev_here && en_q[GLB_EN_BIT]) hit_vec = ev_src & en_q[SRC_N-1:0];
  end

  always_comb begin
    clr_vec = '0;
    if (sts_wr) clr_vec = wr_data[SRC_N-1:0] & wr_mask[SRC_N-1:0];
  end

  // event wins over a clear of the same bit
  assign sts_nxt = (sts_q & ~clr_vec) | hit_vec;
  assign hit     = |hit_vec;
  assign clr_any = |clr_vec;

  always_comb begin
    en_nxt = en_q;
    if (en_wr) en_nxt = (en_q & ~wr_mask) | (wr_data & wr_mask & EN_KEEP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= EN_RESET;
      sts_q <= '0;
    end else begin
      en_q  <= en_nxt;
      sts_q <= sts_nxt;
    end
  end
endmodule

// File: rtl/irqc_line.sv
module irqc_line (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic drop,
  output logic line
);
  always_ff @(posedge clk) begin
    if (!rst_n)     line <= 1'b0;
    else if (raise) line <= 1'b1;
    else if (drop)  line <= 1'b0;
  end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter int LW = 3,
  parameter logic [3:0] VEC_NUM = 4'd11
) (
  input  logic [LW-1:0]            rd_loc,
  input  logic [1:0]               rd_sel,
  input  logic [NUM_LOC*DW-1:0]    en_flat,
  input  logic [NUM_LOC*SRC_N-1:0] sts_flat,
  output logic [DW-1:0]            rd_data
);
  logic [DW-1:0] en_pick;
  logic [SRC_N-1:0] sts_pick;

  always_comb begin
    en_pick  = '0;
    sts_pick = '0;
    for (int l = 0; l < NUM_LOC; l++) begin
      if (rd_loc == LW'(l)) begin
        en_pick  = en_pick  | en_flat[l*DW +: DW];
        sts_pick = sts_pick | sts_flat[l*SRC_N +: SRC_N];
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(rd_sel))
      SEL_ENABLE: rd_data = en_pick;
      SEL_STATUS: rd_data = DW'(sts_pick);
      SEL_VECTOR: rd_data = DW'(VEC_NUM);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter logic [3:0] VEC_NUM = 4'd11,
  localparam int LW = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [LW-1:0]    act_loc,
  input  logic [LW-1:0]    ev_loc,
  input  logic [SRC_N-1:0] ev_src,
  input  logic             wr_en,
  input  logic [LW-1:0]    wr_loc,
  input  logic [1:0]       wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [BE_N-1:0]  wr_be,
  input  logic [LW-1:0]    rd_loc,
  input  logic [1:0]       rd_sel,
  output logic [DW-1:0]    rd_data,
  output logic             irq_line
);
  localparam logic [LW:0] NUM_LOC_V = (LW+1)'(NUM_LOC);

  logic [DW-1:0]            wmask;
  logic                     act_ok;
  logic                     wr_ok;
  logic                     en_wr_ok;
  logic                     sts_wr_ok;
  logic [NUM_LOC*DW-1:0]    en_flat;
  logic [NUM_LOC*SRC_N-1:0] sts_flat;
  logic [NUM_LOC-1:0]       hit_l;
  logic [NUM_LOC-1:0]       drop_l;
  logic                     any_hit;

  assign wmask     = lane_mask(wr_be);
  assign act_ok    = act_valid && ({1'b0, act_loc} < NUM_LOC_V);
  assign wr_ok     = wr_en && act_ok && (wr_loc == act_loc);
  assign en_wr_ok  = wr_ok && (reg_sel_e'(wr_sel) == SEL_ENABLE);
  assign sts_wr_ok = wr_ok && (reg_sel_e'(wr_sel) == SEL_STATUS);

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_loc
    logic [SRC_N-1:0] sts_nxt;
    logic             clr_any;
    logic             mine;

    assign mine = (wr_loc == LW'(l));

    irqc_loc_regs u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .ev_here (ev_loc == LW'(l)),
      .ev_src  (ev_src),
      .en_wr   (en_wr_ok && mine),
      .sts_wr  (sts_wr_ok && mine),
      .wr_data (wr_data),
      .wr_mask (wmask),
      .en_q    (en_flat[l*DW +: DW]),
      .sts_q   (sts_flat[l*SRC_N +: SRC_N]),
      .sts_nxt (sts_nxt),
      .hit     (hit_l[l]),
      .clr_any (clr_any)
    );

    assign drop_l[l] = sts_wr_ok && mine && clr_any && (sts_nxt == '0);
  end

  assign any_hit = |hit_l;

  irqc_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .raise (any_hit),
    .drop  (|drop_l),
    .line  (irq_line)
  );

  irqc_rd_mux #(
    .NUM_LOC (NUM_LOC),
    .LW      (LW),
    .VEC_NUM (VEC_NUM)
  ) u_rd (
    .rd_loc   (rd_loc),
    .rd_sel   (rd_sel),
    .en_flat  (en_flat),
    .sts_flat (sts_flat),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int NUM_LOC = 5,
  parameter logic [3:0] VEC_NUM = 4'd11
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [1:0]               wr_sel,
  input logic [1:0]               rd_sel,
  input logic [DW-1:0]            rd_data,
  input logic                     irq_line,
  input logic                     any_hit,
  input logic                     wr_ok,
  input logic [NUM_LOC*DW-1:0]    en_flat,
  input logic [NUM_LOC*SRC_N-1:0] sts_flat
);
  localparam logic [NUM_LOC*DW-1:0] KEEP_ALL = {NUM_LOC{EN_KEEP}};

  p_hit_sets_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |=> irq_line);

  p_rise_needs_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_line) |-> $past(any_hit));

  p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_line) |-> $past(wr_en && wr_sel == 2'd1 && wr_ok));

  p_blocked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok && !any_hit) |=> ($stable(sts_flat) && $stable(en_flat)));

  p_enable_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_flat & ~KEEP_ALL) == '0);

  p_vector_fixed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd2) |-> (rd_data == DW'(VEC_NUM)));
endmodule

bind irqc_top irqc_checker #(.NUM_LOC(NUM_LOC), .VEC_NUM(VEC_NUM)) u_chk (.*);

// File: tb/irqc_top_test.sv
`timescale 1ns/1ps
module irqc_top_test;
  localparam int NL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        act_valid = 1'b0;
  logic [2:0]  act_loc = '0;
  logic [2:0]  ev_loc = '0;
  logic [3:0]  ev_src = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_loc = '0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [2:0]  rd_loc = '0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        irq_line;

  irqc_top uut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_loc(act_loc),
    .ev_loc(ev_loc), .ev_src(ev_src), .wr_en(wr_en), .wr_loc(wr_loc),
    .wr_sel(wr_sel), .wr_data(wr_data), .wr_be(wr_be), .rd_loc(rd_loc),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq_line(irq_line)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference
  logic [31:0] m_en [NL];
  logic [3:0]  m_sts [NL];
  bit          m_irq;

  function automatic logic [31:0] bmask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = be[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  always @(posedge clk) begin
    logic [3:0]  h [NL];
    logic [3:0]  clr;
    logic [31:0] mk;
    bit any, ok;
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) begin m_en[l] = 32'h10; m_sts[l] = 4'h0; end
      m_irq = 1'b0;
    end else begin
      any = 1'b0;
      for (int l = 0; l < NL; l++) begin
        h[l] = (ev_loc == l && m_en[l][31]) ? (ev_src & m_en[l][3:0]) : 4'h0;
        if (h[l] != 0) any = 1'b1;
      end
      ok  = wr_en && act_valid && (act_loc < NL) && (wr_loc == act_loc);
      mk  = bmask(wr_be);
      clr = 4'h0;
      if (ok && wr_sel == 2'd0)
        m_en[wr_loc] = (m_en[wr_loc] & ~mk) | (wr_data & mk & 32'h8000_003F);
      if (ok && wr_sel == 2'd1) clr = wr_data[3:0] & mk[3:0];
      for (int l = 0; l < NL; l++)
        m_sts[l] = (m_sts[l] & ~((l == wr_loc) ? clr : 4'h0)) | h[l];
      if (any) m_irq = 1'b1;
      else if (clr != 0 && m_sts[wr_loc] == 0) m_irq = 1'b0;
    end
  end

  // line compared against the model on every clock (R1/R7/R11)
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      n_chk++;
      if (irq_line !== m_irq) begin
        n_err++;
        $display("FAIL R7/R11 line per-cycle: actual=%0b expected=%0b at %0t",
                 irq_line, m_irq, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd_chk(input int loc, input int sel, input logic [31:0] exp, input string tag);
    rd_loc = 3'(loc);
    rd_sel = 2'(sel);
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic set_act(input bit v, input int loc);
    act_valid = v;
    act_loc   = 3'(loc);
    @(negedge clk);
  endtask

  task automatic wr(input int loc, input int sel, input logic [31:0] d, input logic [3:0] be);
    wr_en = 1'b1; wr_loc = 3'(loc); wr_sel = 2'(sel); wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ev(input int loc, input logic [3:0] src);
    ev_loc = 3'(loc); ev_src = src;
    @(negedge clk);
    ev_src = 4'h0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R9 reset state
    for (int l = 0; l < NL; l++) begin
      rd_chk(l, 0, 32'h0000_0010, "R9 enable reset");
      rd_chk(l, 1, 32'h0, "R9 status reset");
    end
    chk("R9 line reset", {31'b0, irq_line}, 32'h0);

    set_act(1'b1, 0);
    ev(0, 4'hF);
    rd_chk(0, 1, 32'h0, "R1 no global enable (reset)");

    wr(0, 0, 32'h0000_000F, 4'hF);
    ev(0, 4'hF);
    rd_chk(0, 1, 32'h0, "R1 sources on, global off");

    wr(0, 0, 32'hFFFF_FFFF, 4'h1);
    rd_chk(0, 0, 32'h0000_003F, "R6 one lane written");
    wr(0, 0, 32'hFFFF_FFFF, 4'hF);
    rd_chk(0, 0, 32'h8000_003F, "R5 only kept bits stored");
    wr(0, 0, 32'h8000_0002, 4'h9);
    rd_chk(0, 0, 32'h8000_0002, "R6 lanes 0 and 3");

    ev(0, 4'b1101);
    rd_chk(0, 1, 32'h0, "R1 disabled sources");
    chk("R11 line stays low", {31'b0, irq_line}, 32'h0);
    ev(0, 4'b0010);
    rd_chk(0, 1, 32'h2, "R2 command ready is bit 1");
    chk("R11 line raised", {31'b0, irq_line}, 32'h1);

    wr(0, 0, 32'h8000_000F, 4'hF);
    ev(0, 4'b1100);
    rd_chk(0, 1, 32'hE, "R2 completion sets bits 2 and 3");

    wr(2, 1, 32'hF, 4'hF);
    rd_chk(0, 1, 32'hE, "R4 status write from other locality");
    wr(2, 0, 32'h8000_000F, 4'hF);
    rd_chk(2, 0, 32'h0000_0010, "R4 enable write from other locality");

    wr(0, 1, 32'hFFFF_FFF0, 4'hF);
    rd_chk(0, 1, 32'hE, "R3 upper bits clear nothing");
    wr(0, 1, 32'hF, 4'hE);
    rd_chk(0, 1, 32'hE, "R6 lane 0 disabled");

    wr(0, 1, 32'h2, 4'hF);
    rd_chk(0, 1, 32'hC, "R3 clear bit 1");
    chk("R7 line held with bits left", {31'b0, irq_line}, 32'h1);

    // R8: event and clear in the same cycle
    ev_loc = 3'd0; ev_src = 4'b0001;
    wr(0, 1, 32'hD, 4'hF);
    ev_src = 4'h0;
    rd_chk(0, 1, 32'h1, "R8 event wins over clear");
    chk("R8 line held", {31'b0, irq_line}, 32'h1);

    wr(0, 1, 32'h1, 4'hF);
    rd_chk(0, 1, 32'h0, "R3 last bit cleared");
    chk("R7 line dropped", {31'b0, irq_line}, 32'h0);

    rd_chk(0, 2, 32'd11, "R10 vector value");
    wr(0, 2, 32'h0, 4'hF);
    rd_chk(3, 2, 32'd11, "R10 vector write ignored");

    ev(0, 4'b0001);
    set_act(1'b0, 0);
    wr(0, 1, 32'hF, 4'hF);
    rd_chk(0, 1, 32'h1, "R4 no active locality");
    chk("R4 line unchanged", {31'b0, irq_line}, 32'h1);
    set_act(1'b1, 0);
    wr(0, 1, 32'hF, 4'hF);

    // R7: writer's status zero drops the line even with another locality pending
    set_act(1'b1, 1);
    wr(1, 0, 32'h8000_0001, 4'hF);
    set_act(1'b1, 0);
    ev(1, 4'b0001);
    ev(0, 4'b0010);
    wr(0, 1, 32'h2, 4'hF);
    rd_chk(1, 1, 32'h1, "R7 other locality keeps status");
    chk("R7 line dropped by writer", {31'b0, irq_line}, 32'h0);

    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule